// File: doc/BRIEF.md
# Strobe-handshake register slave

This block is a byte-wide slave that sits on a processor bus driven by an asynchronous master. The master selects the device with an active-low select, puts a six-bit address and a direction on the bus, then raises a data strobe. The control lines pass through a two-stage synchroniser into the block's clock domain. Once the synchronised view shows an access, the block does one of two things. A write loads the data byte into one of 64 internal byte registers. A read latches that register's contents for return.

After the access is done, the block pulls its acknowledge low. On the pin this is an open-drain output, so it appears here as an enable `ack_oe`: a 1 means the line is driven low. The acknowledge holds until the master drops the strobe or deselects the device. It then releases one cycle after the synchroniser shows that change. The data bus is split into input, output and tri-state enable. The output is driven only while a read is being acknowledged and the raw pins still show select low, strobe high and read direction.

Top module: `strobe_slave`

## Requirements
- R1: After reset, `ack_oe` and `data_oe` are 0 and every one of the 64 registers reads back as 0x00.
- R2: With `cs_n`=0, `strobe`=1 and `rd_wr_n`=0 held, the byte on `data_in` is stored into the register selected by `addr`.
- R3: `ack_oe` rises to 1 exactly three rising clock edges after `cs_n`=0 and `strobe`=1 are first presented, and stays 1 while they are held.
- R4: When `strobe` falls or `cs_n` rises, `ack_oe` returns to 0 exactly three rising clock edges later.
- R5: During an acknowledged read (`rd_wr_n`=1), `data_out` carries the value of the addressed register and `data_oe` is 1.
- R6: `data_oe` is 0 in any cycle where `cs_n` is 1, `strobe` is 0 or `rd_wr_n` is 0. This takes effect at once, with no clock delay.
- R7: Each strobe assertion writes exactly once. Changing `data_in` after the acknowledge, while the strobe is still held, leaves the stored value unchanged.
- R8: A strobe pulse while `cs_n` is 1 has no effect: no acknowledge, and no register changes.
- R9: The 64 registers are independent. A write to one address leaves the other 63 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low device select |
| strobe | input | 1 | Active-high data strobe |
| rd_wr_n | input | 1 | Direction: 1 read, 0 write |
| addr | input | 6 | Register address |
| data_in | input | 8 | Bus data seen by the slave |
| data_out | output | 8 | Read data driven onto the bus |
| data_oe | output | 1 | Tri-state enable for `data_out` |
| ack_oe | output | 1 | 1 pulls the open-drain acknowledge low |

## Verification
The bench counts edges from the moment the strobe is presented to the rise of the acknowledge, and again from strobe removal to its release. A design with one synchroniser stage too few or too many therefore shows a latency of 2 or 4 instead of 3. The bench changes the write data while an acknowledged strobe is still held. A design that writes on every cycle of the strobe would store the late byte instead of the first one. Strobe pulses with the device deselected must leave every register intact. Right after the strobe falls, the bench checks that the data enable has already dropped, which catches an enable taken from the delayed, synchronised copy of the strobe. A sweep over all 64 addresses catches address decode faults that alias registers.

// File: rtl/strb_pkg.sv
package strb_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } hs_state_e;

endpackage

// File: rtl/strb_sync.sv
module strb_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[g] <= RST_VAL;
                end else begin
                    stg_q[g] <= stg_d[g];
                end
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/strb_regfile.sv
module strb_regfile #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[addr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/strb_ctl.sv
module strb_ctl
    import strb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_s_n,
    input  logic              stb_s,
    input  logic              dir_rd_s,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wr_en,
    output logic              ack,
    output logic              rd_ack,
    output logic [DATA_W-1:0] rd_hold
);

    typedef struct packed {
        hs_state_e         state;
        logic              rd;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic wr_en_d;

    always_comb begin
        ctl_d   = ctl_q;
        wr_en_d = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (!sel_s_n && stb_s) begin
                    ctl_d.state = ST_ACK;
                    ctl_d.rd    = dir_rd_s;
                    if (dir_rd_s) begin
                        ctl_d.rdata = mem_rdata;
                    end else begin
                        wr_en_d = 1'b1;
                    end
                end
            end
            ST_ACK: begin
                if (sel_s_n || !stb_s) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.rd    = 1'b0;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, rd: 1'b0, rdata: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wr_en   = wr_en_d;
    assign ack     = (ctl_q.state == ST_ACK);
    assign rd_ack  = ack && ctl_q.rd;
    assign rd_hold = ctl_q.rdata;

endmodule

// File: rtl/strobe_slave.sv
module strobe_slave #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              strobe,
    input  logic              rd_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              ack_oe
);

    localparam int CTL_W = 3;
    localparam logic [CTL_W-1:0] CTL_IDLE = 3'b101;

    logic [CTL_W-1:0]  ctl_s;
    logic              wr_en;
    logic              rd_ack;
    logic [DATA_W-1:0] mem_rdata;

    strb_sync #(
        .WIDTH   (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, strobe, rd_wr_n}),
        .sync_o  (ctl_s)
    );

    strb_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (data_in),
        .rdata  (mem_rdata)
    );

    strb_ctl #(
        .DATA_W (DATA_W)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_s_n   (ctl_s[2]),
        .stb_s     (ctl_s[1]),
        .dir_rd_s  (ctl_s[0]),
        .mem_rdata (mem_rdata),
        .wr_en     (wr_en),
        .ack       (ack_oe),
        .rd_ack    (rd_ack),
        .rd_hold   (data_out)
    );

    assign data_oe = rd_ack && !cs_n && strobe && rd_wr_n;

endmodule

// File: rtl/strobe_slave_chk.sv
module strobe_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic strobe,
    input logic rd_wr_n,
    input logic data_oe,
    input logic ack_oe
);

    // R3
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_oe) |-> $past(!cs_n && strobe, 3));

    // R4
    ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_oe) |-> $past(cs_n || !strobe, 3));

    // R8
    desel_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !ack_oe);

    // R5
    oe_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> ack_oe);

    // R6
    oe_bus_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!cs_n && strobe && rd_wr_n));

endmodule

bind strobe_slave strobe_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .strobe  (strobe),
    .rd_wr_n (rd_wr_n),
    .data_oe (data_oe),
    .ack_oe  (ack_oe)
);

// File: tb/strobe_slave_tb.sv
module strobe_slave_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       strobe = 1'b0;
    logic       rd_wr_n = 1'b1;
    logic [5:0] addr = '0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic       data_oe;
    logic       ack_oe;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    strobe_slave u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .strobe  (strobe),
        .rd_wr_n (rd_wr_n),
        .addr    (addr),
        .data_in (data_in),
        .data_out(data_out),
        .data_oe (data_oe),
        .ack_oe  (ack_oe)
    );

    // behavioural reference: the control view lags the pins by two edges
    bit   h_cs [$];
    bit   h_stb [$];
    bit   h_rd [$];
    bit   m_ack;
    bit   m_rd;
    byte  m_mem [64];
    byte  m_rdata;

    task automatic model_clear();
        h_cs = '{1, 1}; h_stb = '{0, 0}; h_rd = '{1, 1};
        m_ack = 0; m_rd = 0; m_rdata = 0;
        foreach (m_mem[i]) m_mem[i] = 0;
    endtask

    initial model_clear();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_clear();
        end else begin
            bit vc, vs, vr;
            vc = h_cs.pop_front(); vs = h_stb.pop_front(); vr = h_rd.pop_front();
            h_cs.push_back(cs_n); h_stb.push_back(strobe); h_rd.push_back(rd_wr_n);
            if (!m_ack) begin
                if (!vc && vs) begin
                    m_ack = 1; m_rd = vr;
                    if (vr) m_rdata = m_mem[addr];
                    else    m_mem[addr] = data_in;
                end
            end else if (vc || !vs) begin
                m_ack = 0; m_rd = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_oe;
            exp_oe = m_ack && m_rd && !cs_n && strobe && rd_wr_n;
            chk(ack_oe == m_ack, {cur_req, " ack"}, ack_oe, m_ack);
            chk(data_oe == exp_oe, {cur_req, " oe"}, data_oe, exp_oe);
            if (exp_oe) chk(data_out == m_rdata, {cur_req, " data"}, data_out, m_rdata);
        end
    end

    // one full handshake; optional late data change to probe write-once
    task automatic access(input bit rd, input logic [5:0] a, input logic [7:0] d,
                          input bit late_chg, output int up, output int dn,
                          output logic [7:0] rv);
        @(negedge clk); #2;
        addr = a; data_in = d; rd_wr_n = rd; cs_n = 0; strobe = 1;
        up = 0;
        do begin @(negedge clk); up++; end while (!ack_oe && up < 50);
        rv = data_out;
        if (late_chg) begin
            #2 data_in = ~d;
            repeat (4) @(negedge clk);
        end
        @(negedge clk); #2;
        strobe = 0;
        #1 chk(data_oe == 0, "R6 oe drop", data_oe, 0);
        #1 cs_n = 1;
        dn = 0;
        do begin @(negedge clk); dn++; end while (ack_oe && dn < 50);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_bad++; n_vec++;
                $display("FAIL watchdog: actual %0d expected < 100000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int up, dn;
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        chk(ack_oe == 0, "R1 reset ack", ack_oe, 0);
        chk(data_oe == 0, "R1 reset oe", data_oe, 0);
        #2 rst_n = 1;

        cur_req = "R1";
        for (int a = 0; a < 64; a += 21) begin
            access(1, a[5:0], 8'h00, 0, up, dn, rv);
            chk(rv == 8'h00, "R1 reset contents", rv, 0);
        end

        cur_req = "R2";
        access(0, 6'd5, 8'hA5, 0, up, dn, rv);
        chk(up == 3, "R3 ack latency", up, 3);
        chk(dn == 3, "R4 release latency", dn, 3);
        cur_req = "R5";
        access(1, 6'd5, 8'h00, 0, up, dn, rv);
        chk(rv == 8'hA5, "R2/R5 readback", rv, 8'hA5);
        chk(up == 3, "R3 read ack latency", up, 3);

        cur_req = "R7";
        access(0, 6'd9, 8'h3C, 1, up, dn, rv);
        access(1, 6'd9, 8'h00, 0, up, dn, rv);
        chk(rv == 8'h3C, "R7 write once", rv, 8'h3C);

        cur_req = "R8";
        @(negedge clk); #2;
        addr = 6'd9; data_in = 8'hFF; rd_wr_n = 0; cs_n = 1; strobe = 1;
        repeat (6) begin
            @(negedge clk);
            chk(ack_oe == 0, "R8 no ack deselected", ack_oe, 0);
        end
        #2 strobe = 0;
        repeat (3) @(negedge clk);
        access(1, 6'd9, 8'h00, 0, up, dn, rv);
        chk(rv == 8'h3C, "R8 register kept", rv, 8'h3C);

        cur_req = "R4";
        @(negedge clk); #2;
        addr = 6'd5; rd_wr_n = 1; cs_n = 0; strobe = 1;
        up = 0;
        do begin @(negedge clk); up++; end while (!ack_oe && up < 50);
        #2 cs_n = 1;
        #1 chk(data_oe == 0, "R6 oe drop on deselect", data_oe, 0);
        dn = 0;
        do begin @(negedge clk); dn++; end while (ack_oe && dn < 50);
        chk(dn == 3, "R4 release on deselect", dn, 3);
        #2 strobe = 0;

        cur_req = "R9";
        for (int a = 0; a < 64; a++) begin
            logic [7:0] v;
            v = 8'(a * 37 + 11);
            access(0, a[5:0], v, 0, up, dn, rv);
        end
        for (int a = 0; a < 64; a++) begin
            logic [7:0] v;
            v = 8'(a * 37 + 11);
            access(1, a[5:0], 8'h00, 0, up, dn, rv);
            chk(rv == v, "R9 address sweep", rv, v);
        end

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule